// File: doc/BRIEF.md
# Single-Wire Bus Seconds Clock Function Unit

This block is the function layer of a single-wire bus slave that keeps time. Once the addressing layer above it reports that this device has been selected, the unit receives an eight-bit function code from the bit-level handshake. It then serves one of two operations. The first returns a frozen copy of the time. The second sets the time and the control flags.

Timekeeping is a 32-bit binary count of seconds. It advances on a one-cycle 1 Hz enable pulse, but only while the oscillator-enable state is on. A single 32-bit holding buffer has two uses. A read loads a snapshot of the count into it. A write stages the new time in it, and that time reaches the counter only when the master next resets the bus. The control byte holds four free user flags and two copies of the oscillator-enable state. Writes to the control byte apply at once.

The surrounding link layer turns bus slots into single-cycle strobes: a written bit, a read slot, a bus reset, and a select. It drives the line low whenever `tx_bit_o` is 0 during a read slot.

Top module: `rtc_1w_clock_fn`

## Requirements
- R1: After reset the seconds count is 0, the oscillator is off, the user flags are 0 and `tx_bit_o` is 1.
- R2: The count rises by one on each `tick_i` pulse only while the oscillator is on. It wraps from FFFFFFFFh to 0, and without a tick or a commit it holds its value.
- R3: Function code 66h (bits received least significant first) copies the count into the buffer on the clock edge that takes the eighth code bit. Ticks after that edge do not alter the data read out.
- R4: In a read, each `rd_slot_i` strobe moves to the next bit, and `tx_bit_o` presents the current bit. The order is the control byte first, then count bytes 0 (least significant) to 3, each byte least significant bit first. After the 40th bit the sequence repeats from the first control bit. Outside a read, `tx_bit_o` stays 1.
- R5: The control byte reads with bits 1:0 = 0, bits 3:2 = oscillator state (11b on, 00b off) and bits 7:4 = the user flags last written.
- R6: Function code 99h takes the first following byte as the control byte. Its oscillator state and user flags apply on the edge that takes its eighth bit, before any bus reset.
- R7: When bits 2 and 3 of a written control byte differ, bit 3 alone sets the oscillator state.
- R8: After the control byte, the next four written bytes fill the buffer least significant byte first. The count keeps its old value until the next `bus_rst_i`, and on that edge it takes the buffered value.
- R9: A write ended by `bus_rst_i` before all four time bytes have arrived leaves the count unchanged.
- R10: Any function code other than 66h or 99h makes the unit ignore bits and read slots until the next bus reset. `tx_bit_o` stays 1 and the count and control byte stay the same.
- R11: Written bits that arrive before `sel_i` after a bus reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| bus_rst_i | input | 1 | One-cycle strobe: master issued a bus reset pulse |
| sel_i | input | 1 | One-cycle strobe: addressing layer selected this device |
| wr_vld_i | input | 1 | One-cycle strobe: a master write slot completed |
| wr_bit_i | input | 1 | Value of the written bit, valid with `wr_vld_i` |
| rd_slot_i | input | 1 | One-cycle strobe: a master read slot consumed `tx_bit_o` |
| tick_i | input | 1 | 1 Hz enable pulse, one cycle wide |
| tx_bit_o | output | 1 | Bit to present in the next read slot (1 = release) |
| time_o | output | 32 | Current seconds count |

## Verification
The read operation is tried with the count at 0, at a value written just before, and after ticks that arrive between the code and the readout. This separates a true snapshot from a live view. A read run past 40 bits shows whether the pointer wraps to the control byte or runs into stale bits. Control bytes with matching oscillator bits, and with only bit 3 or only bit 2 set, separate the precedence rule from a plain OR or a use of bit 2. Writes cut off after two time bytes, full writes checked before and after the reset, a count of all ones, an unknown code, and bits sent without a select show apart commit timing, wrap, and the two ignore paths.

// File: rtl/rtc_1w_pkg.sv
package rtc_1w_pkg;

    localparam int BYTE_W = 8;

    // function codes as assembled from the bit stream (first bit = bit 0)
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h66;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h99;

    // control byte layout
    localparam int CTL_OSC_LO = 2;
    localparam int CTL_OSC_HI = 3;   // wins on a mismatch
    localparam int CTL_USR_LO = 4;
    localparam int USR_W      = BYTE_W - CTL_USR_LO;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_WRITE,
        ST_HALT
    } fn_state_e;

endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && run_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_fn_seq.sv
module rtc_fn_seq
    import rtc_1w_pkg::*;
#(
    parameter int CNT_BYTES = 4,
    localparam int CNT_W    = CNT_BYTES * BYTE_W,
    localparam int FRAME_W  = BYTE_W + CNT_W,
    localparam int PTR_W    = $clog2(FRAME_W),
    localparam int BITC_W   = $clog2(BYTE_W),
    localparam int IDX_W    = $clog2(CNT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_i,
    input  logic             sel_i,
    input  logic             wr_vld_i,
    input  logic             wr_bit_i,
    input  logic             rd_slot_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] buf_o,
    output logic             osc_o,
    output logic [USR_W-1:0] usr_o,
    output logic             commit_o,
    output logic             rd_active_o,
    output logic [PTR_W-1:0] rd_ptr_o
);

    typedef struct packed {
        fn_state_e         state;
        logic [BYTE_W-1:0] shreg;
        logic [BITC_W-1:0] bitc;
        logic [IDX_W-1:0]  bidx;
        logic [CNT_W-1:0]  hold;
        logic              osc;
        logic [USR_W-1:0]  usr;
        logic              pending;
        logic [PTR_W-1:0]  ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [BYTE_W-1:0] shifted;
    logic              byte_done;

    always_comb begin
        seq_d     = seq_q;
        shifted   = {wr_bit_i, seq_q.shreg[BYTE_W-1:1]};
        byte_done = wr_vld_i && (seq_q.bitc == BITC_W'(BYTE_W - 1));
        commit_o  = bus_rst_i && seq_q.pending;

        if (bus_rst_i) begin
            seq_d.state   = ST_IDLE;
            seq_d.bitc    = '0;
            seq_d.bidx    = '0;
            seq_d.pending = 1'b0;
            seq_d.ptr     = '0;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    if (sel_i) begin
                        seq_d.state = ST_CMD;
                        seq_d.bitc  = '0;
                    end
                end
                ST_CMD: begin
                    if (wr_vld_i) begin
                        seq_d.shreg = shifted;
                        seq_d.bitc  = seq_q.bitc + BITC_W'(1);
                        if (byte_done) begin
                            seq_d.bitc = '0;
                            if (shifted == OP_READ) begin
                                seq_d.hold  = cnt_i;
                                seq_d.ptr   = '0;
                                seq_d.state = ST_READ;
                            end else if (shifted == OP_WRITE) begin
                                seq_d.bidx  = '0;
                                seq_d.state = ST_WRITE;
                            end else begin
                                seq_d.state = ST_HALT;
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (rd_slot_i) begin
                        if (seq_q.ptr == PTR_W'(FRAME_W - 1)) begin
                            seq_d.ptr = '0;
                        end else begin
                            seq_d.ptr = seq_q.ptr + PTR_W'(1);
                        end
                    end
                end
                ST_WRITE: begin
                    if (wr_vld_i) begin
                        seq_d.shreg = shifted;
                        seq_d.bitc  = seq_q.bitc + BITC_W'(1);
                        if (byte_done) begin
                            seq_d.bitc = '0;
                            seq_d.bidx = seq_q.bidx + IDX_W'(1);
                            if (seq_q.bidx == '0) begin
                                seq_d.osc = shifted[CTL_OSC_HI];
                                seq_d.usr = shifted[BYTE_W-1:CTL_USR_LO];
                            end
                            for (int lane = 0; lane < CNT_BYTES; lane++) begin
                                if (seq_q.bidx == IDX_W'(lane + 1)) begin
                                    seq_d.hold[lane*BYTE_W +: BYTE_W] = shifted;
                                end
                            end
                            if (seq_q.bidx == IDX_W'(CNT_BYTES)) begin
                                seq_d.pending = 1'b1;
                                seq_d.state   = ST_HALT;
                            end
                        end
                    end
                end
                default: begin
                    seq_d = seq_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state   <= ST_IDLE;
            seq_q.shreg   <= '0;
            seq_q.bitc    <= '0;
            seq_q.bidx    <= '0;
            seq_q.hold    <= '0;
            seq_q.osc     <= 1'b0;
            seq_q.usr     <= '0;
            seq_q.pending <= 1'b0;
            seq_q.ptr     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign buf_o       = seq_q.hold;
    assign osc_o       = seq_q.osc;
    assign usr_o       = seq_q.usr;
    assign rd_active_o = (seq_q.state == ST_READ);
    assign rd_ptr_o    = seq_q.ptr;

endmodule

// File: rtl/rtc_rd_frame.sv
module rtc_rd_frame
    import rtc_1w_pkg::*;
#(
    parameter int CNT_BYTES = 4,
    localparam int CNT_W    = CNT_BYTES * BYTE_W,
    localparam int FRAME_W  = BYTE_W + CNT_W,
    localparam int PTR_W    = $clog2(FRAME_W)
) (
    input  logic             active_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             osc_i,
    input  logic [USR_W-1:0] usr_i,
    input  logic [CNT_W-1:0] hold_i,
    output logic             bit_o
);

    logic [BYTE_W-1:0]  ctl_byte;
    logic [FRAME_W-1:0] frame;

    always_comb begin
        ctl_byte                           = '0;
        ctl_byte[CTL_OSC_LO]               = osc_i;
        ctl_byte[CTL_OSC_HI]               = osc_i;
        ctl_byte[BYTE_W-1:CTL_USR_LO]      = usr_i;
        frame                              = {hold_i, ctl_byte};
        bit_o                              = active_i ? frame[ptr_i] : 1'b1;
    end

endmodule

// File: rtl/rtc_1w_clock_fn.sv
module rtc_1w_clock_fn
    import rtc_1w_pkg::*;
#(
    parameter int CNT_BYTES = 4,
    localparam int CNT_W    = CNT_BYTES * BYTE_W,
    localparam int FRAME_W  = BYTE_W + CNT_W,
    localparam int PTR_W    = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_i,
    input  logic             sel_i,
    input  logic             wr_vld_i,
    input  logic             wr_bit_i,
    input  logic             rd_slot_i,
    input  logic             tick_i,
    output logic             tx_bit_o,
    output logic [CNT_W-1:0] time_o
);

    logic [CNT_W-1:0] hold;
    logic             osc_en;
    logic [USR_W-1:0] usr;
    logic             commit;
    logic             rd_active;
    logic [PTR_W-1:0] rd_ptr;

    rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (osc_en),
        .load_i     (commit),
        .load_val_i (hold),
        .cnt_o      (time_o)
    );

    rtc_fn_seq #(.CNT_BYTES(CNT_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rst_i   (bus_rst_i),
        .sel_i       (sel_i),
        .wr_vld_i    (wr_vld_i),
        .wr_bit_i    (wr_bit_i),
        .rd_slot_i   (rd_slot_i),
        .cnt_i       (time_o),
        .buf_o       (hold),
        .osc_o       (osc_en),
        .usr_o       (usr),
        .commit_o    (commit),
        .rd_active_o (rd_active),
        .rd_ptr_o    (rd_ptr)
    );

    rtc_rd_frame #(.CNT_BYTES(CNT_BYTES)) u_frame (
        .active_i (rd_active),
        .ptr_i    (rd_ptr),
        .osc_i    (osc_en),
        .usr_i    (usr),
        .hold_i   (hold),
        .bit_o    (tx_bit_o)
    );

endmodule

// File: rtl/rtc_1w_clock_fn_chk.sv
module rtc_1w_clock_fn_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rst_i,
    input logic             wr_vld_i,
    input logic             tick_i,
    input logic             tx_bit_o,
    input logic [CNT_W-1:0] time_o,
    input logic             osc_en,
    input logic             rd_active
);

    // R2: no tick and no bus reset -> count holds
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !bus_rst_i) |=> $stable(time_o));

    // R2: a tick with the oscillator on steps the count by one, wrapping
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && osc_en && !bus_rst_i) |=> (time_o == $past(time_o) + CNT_W'(1)));

    // R2: with the oscillator off and no reset the count never moves
    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !bus_rst_i) |=> $stable(time_o));

    // R6: oscillator state only changes on a written bit
    a_r6_osc_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld_i |=> $stable(osc_en));

    // R4, R10: line released whenever no read is in progress
    a_r4_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> tx_bit_o);

endmodule

bind rtc_1w_clock_fn rtc_1w_clock_fn_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst_i (bus_rst_i),
    .wr_vld_i  (wr_vld_i),
    .tick_i    (tick_i),
    .tx_bit_o  (tx_bit_o),
    .time_o    (time_o),
    .osc_en    (osc_en),
    .rd_active (rd_active)
);

// File: tb/rtc_1w_clock_fn_bench.sv
module rtc_1w_clock_fn_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst_i = 1'b0;
    logic        sel_i = 1'b0;
    logic        wr_vld_i = 1'b0;
    logic        wr_bit_i = 1'b0;
    logic        rd_slot_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        tx_bit_o;
    logic [31:0] time_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_1w_clock_fn u_rtc_1w_clock_fn (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst_i (bus_rst_i),
        .sel_i     (sel_i),
        .wr_vld_i  (wr_vld_i),
        .wr_bit_i  (wr_bit_i),
        .rd_slot_i (rd_slot_i),
        .tick_i    (tick_i),
        .tx_bit_o  (tx_bit_o),
        .time_o    (time_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_bus_rst();
        @(negedge clk); bus_rst_i = 1'b1;
        @(negedge clk); bus_rst_i = 1'b0;
    endtask

    task automatic pulse_sel();
        @(negedge clk); sel_i = 1'b1;
        @(negedge clk); sel_i = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); wr_vld_i = 1'b1; wr_bit_i = b[i];
            @(negedge clk); wr_vld_i = 1'b0;
        end
    endtask

    task automatic read_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); b[i] = tx_bit_o; rd_slot_i = 1'b1;
            @(negedge clk); rd_slot_i = 1'b0;
        end
    endtask

    task automatic start_fn(input logic [7:0] code);
        pulse_bus_rst();
        pulse_sel();
        send_byte(code);
    endtask

    task automatic write_all(input logic [7:0] ctl, input logic [31:0] t);
        start_fn(8'h99);
        send_byte(ctl);
        for (int k = 0; k < 4; k++) send_byte(t[k*8 +: 8]);
    endtask

    task automatic read_all(output logic [7:0] ctl, output logic [31:0] t);
        logic [7:0] b;
        start_fn(8'h66);
        read_byte(ctl);
        for (int k = 0; k < 4; k++) begin
            read_byte(b);
            t[k*8 +: 8] = b;
        end
    endtask

    task automatic t_reset_state();
        logic [7:0] c; logic [31:0] t;
        check("R1 time after reset", time_o, 32'h0);
        check("R1 tx released after reset", {31'h0, tx_bit_o}, 32'h1);
        read_all(c, t);
        check("R1 R5 control byte after reset", {24'h0, c}, 32'h0);
        check("R1 time read after reset", t, 32'h0);
    endtask

    task automatic t_osc_off();
        pulse_bus_rst();
        pulse_tick(3);
        check("R2 no count with oscillator off", time_o, 32'h0);
    endtask

    task automatic t_short_write();
        start_fn(8'h99);
        send_byte(8'h5C);
        pulse_tick(3);
        check("R6 control byte effective before reset", time_o, 32'h3);
        send_byte(8'hAA);
        send_byte(8'hBB);
        pulse_bus_rst();
        check("R9 short write leaves count", time_o, 32'h3);
    endtask

    task automatic t_full_write();
        logic [7:0] c; logic [31:0] t;
        write_all(8'h5C, 32'h1234_5678);
        check("R8 count held before bus reset", time_o, 32'h3);
        pulse_bus_rst();
        check("R8 count loaded on bus reset", time_o, 32'h1234_5678);
        pulse_bus_rst();
        check("R8 second reset does not reload", time_o, 32'h1234_5678);
        pulse_tick(1);
        check("R2 count steps after load", time_o, 32'h1234_5679);
        read_all(c, t);
        check("R5 control byte with flags and osc", {24'h0, c}, 32'h5C);
        check("R4 time bytes order", t, 32'h1234_5679);
    endtask

    task automatic t_snapshot_wrap();
        logic [7:0] c; logic [7:0] b; logic [31:0] t;
        start_fn(8'h66);
        pulse_tick(2);
        check("R2 live count during read", time_o, 32'h1234_567B);
        read_byte(c);
        for (int k = 0; k < 4; k++) begin
            read_byte(b);
            t[k*8 +: 8] = b;
        end
        check("R3 snapshot unaffected by ticks", t, 32'h1234_5679);
        read_byte(b);
        check("R4 wrap to control byte", {24'h0, b}, 32'h5C);
        read_byte(b);
        check("R4 wrap to time byte 0", {24'h0, b}, 32'h79);
        pulse_bus_rst();
        check("R4 released after read", {31'h0, tx_bit_o}, 32'h1);
    endtask

    task automatic t_precedence();
        logic [7:0] c; logic [31:0] t;
        write_all(8'h08, 32'h0000_0100);
        pulse_bus_rst();
        pulse_tick(1);
        check("R7 bit3 set alone turns osc on", time_o, 32'h0000_0101);
        read_all(c, t);
        check("R7 R5 readback with only bit3 written", {24'h0, c}, 32'h0C);
        write_all(8'h74, 32'h0000_0200);
        pulse_bus_rst();
        pulse_tick(2);
        check("R7 bit2 alone leaves osc off", time_o, 32'h0000_0200);
        read_all(c, t);
        check("R7 R5 readback with only bit2 written", {24'h0, c}, 32'h70);
    endtask

    task automatic t_wrap();
        write_all(8'h0C, 32'hFFFF_FFFF);
        pulse_bus_rst();
        check("R8 all ones loaded", time_o, 32'hFFFF_FFFF);
        pulse_tick(1);
        check("R2 wrap to zero", time_o, 32'h0);
    endtask

    task automatic t_unknown();
        logic [7:0] c; logic [7:0] b; logic [31:0] t;
        start_fn(8'h33);
        send_byte(8'h99);
        send_byte(8'h00);
        for (int k = 0; k < 4; k++) send_byte(8'h55);
        read_byte(b);
        check("R10 line released after unknown code", {24'h0, b}, 32'hFF);
        pulse_bus_rst();
        check("R10 count unchanged after unknown code", time_o, 32'h0);
        read_all(c, t);
        check("R10 control unchanged after unknown code", {24'h0, c}, 32'h0C);
    endtask

    task automatic t_unselected();
        logic [7:0] c; logic [31:0] t;
        pulse_bus_rst();
        send_byte(8'h99);
        send_byte(8'h00);
        for (int k = 0; k < 4; k++) send_byte(8'h77);
        pulse_bus_rst();
        check("R11 count unchanged without select", time_o, 32'h0);
        read_all(c, t);
        check("R11 control unchanged without select", {24'h0, c}, 32'h0C);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_osc_off();
        t_short_write();
        t_full_write();
        t_snapshot_wrap();
        t_precedence();
        t_wrap();
        t_unknown();
        t_unselected();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            finish_run();
        end
    end

endmodule